// File: doc/BRIEF.md
# Fan spin-up sequencer

This block sits between a fan controller's normal duty path and its PWM generator. When the fan is asked to start, it replaces the normal duty with a forced spin-up duty for a bounded time. This gets a stalled rotor turning before the controller's regular duty, which may be low, takes over. Outside spin-up the normal duty passes straight through.

A 6-bit configuration, held in an 8-bit register, sets three things. The time code gives the spin-up length as a number of periodic time-base ticks, doubling with each code step. The duty code selects a forced duty. A fast flag forces full duty and lets a tachometer "minimum speed reached" flag end spin-up early. The settings are captured when spin-up begins, so a register write during a spin-up affects only the next one. Tachometer measurement itself is outside this block; only the comparison result arrives, on `tach_ok`.

Top module: `fan_spinup_seq`

## Requirements
- R1: `cfg_rdata` bits 7:6 always read 0. Bits 5:0 return the value last written through `cfg_we`/`cfg_wdata`, visible in the cycle after the write edge. The layout is bit 5 fast flag, bits 4:3 duty code, bits 2:0 time code. After reset the register reads 0x3F.
- R2: A nonzero time code k makes spin-up last exactly BASE_TICKS·2^(k-1) ticks (50, 100, 200, 400, 800, 1600 or 3200 with the default BASE_TICKS of 50). Spin-up ends at the clock edge that samples the last of those ticks high.
- R3: Time code 000 gives no spin-up, whatever the fast flag and duty code are.
- R4: With the fast flag at 0 and duty code 00 there is no spin-up. With the fast flag at 1, duty code 00 still spins up.
- R5: During spin-up the forced duty is set by the duty code: code 01 gives 2^(DUTY_W-1) (128), code 10 gives 3·2^(DUTY_W-2) (192), and code 11 gives 2^DUTY_W-1 (255). With the fast flag set the forced duty is 255 for any duty code.
- R6: A clock edge that samples `start_req` high, when the previous edge sampled it low, starts spin-up if the configuration allows one. `spin_active` is high from that edge on. While `start_req` stays high, no further spin-up starts.
- R7: In fast mode, an edge that samples `tach_ok` high during spin-up ends it at that edge. In non-fast mode `tach_ok` has no effect.
- R8: An edge that samples `start_req` low during spin-up ends it at once.
- R9: While `spin_active` is low, `eff_duty` equals `norm_duty` in the same cycle, with no register in the path.
- R10: The fast flag, duty code and time code are captured at the start edge. Register writes during spin-up change neither its duty nor its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle time-base pulse (1 kHz nominal) |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration readback |
| norm_duty | input | DUTY_W (8) | Normal duty from the fan controller |
| start_req | input | 1 | Fan-start request level |
| tach_ok | input | 1 | Tachometer speed has reached the minimum setpoint |
| eff_duty | output | DUTY_W (8) | Effective duty to the PWM generator |
| spin_active | output | 1 | Spin-up in progress |

## Verification
`spin_active` and the forced duty change one edge after the start, abort, tachometer or last-tick condition is sampled. A register write shows on `cfg_rdata` one edge after it is sampled. Outside spin-up, `eff_duty` follows `norm_duty` within the same cycle. The bench therefore drives all inputs on the falling edge and samples two time units later. At that point it sees the state from the preceding rising edge together with the inputs just applied. A cycle-level model in the bench advances on the rising edge from the same sampled inputs. It is compared every cycle alongside the directed checks of exact lengths and duty values.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

  // Field order matches the register layout: fast[5], duty[4:3], time[2:0]
  typedef struct packed {
    logic       fast;
    logic [1:0] duty_code;
    logic [2:0] time_code;
  } fsu_cfg_t;

  typedef enum logic {
    FSU_IDLE = 1'b0,
    FSU_SPIN = 1'b1
  } fsu_state_e;

  localparam logic [1:0] DC_OFF  = 2'b00;
  localparam logic [1:0] DC_HALF = 2'b01;
  localparam logic [1:0] DC_3Q   = 2'b10;
  localparam logic [1:0] DC_FULL = 2'b11;

  localparam fsu_cfg_t CFG_RESET = '{fast: 1'b1, duty_code: DC_FULL, time_code: 3'b111};

endpackage

// File: rtl/fsu_rst_sync.sv
module fsu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/fsu_cfg_reg.sv
module fsu_cfg_reg
  import fsu_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output fsu_cfg_t         cfg
);

  localparam int FIELD_W = $bits(fsu_cfg_t);
  localparam int PAD_W   = REG_W - FIELD_W;

  fsu_cfg_t cfg_q;
  fsu_cfg_t cfg_d;
  logic     unused_pad;

  assign unused_pad = ^wdata[REG_W-1:FIELD_W];

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = fsu_cfg_t'(wdata[FIELD_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  assign cfg   = cfg_q;
  assign rdata = {{PAD_W{1'b0}}, cfg_q};

  // R1: a write lands in the field bits on the following edge
  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg_q == $past(wdata[FIELD_W-1:0])));

  // R1: without a write the stored fields hold
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg_q));

endmodule

// File: rtl/fsu_seq.sv
module fsu_seq
  import fsu_pkg::*;
#(
  parameter int BASE_TICKS = 50
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     start_req,
  input  logic     tach_ok,
  input  fsu_cfg_t cfg_i,
  output logic     active,
  output fsu_cfg_t cfg_lat
);

  localparam int MAX_TICKS = BASE_TICKS * 64;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  fsu_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  fsu_cfg_t         lat_q, lat_d;
  logic             start_q;
  logic             start_edge;
  logic             cfg_ok;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] last_cnt;

  assign start_edge = start_req & ~start_q;
  assign cfg_ok     = (cfg_i.time_code != 3'd0) &&
                      (cfg_i.fast || (cfg_i.duty_code != DC_OFF));

  always_comb begin
    limit    = CNT_W'(BASE_TICKS) << (lat_q.time_code - 3'd1);
    last_cnt = limit - CNT_W'(1);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lat_d   = lat_q;
    case (state_q)
      FSU_IDLE: begin
        if (start_edge && cfg_ok) begin
          state_d = FSU_SPIN;
          cnt_d   = '0;
          lat_d   = cfg_i;
        end
      end
      FSU_SPIN: begin
        if (!start_req) begin
          state_d = FSU_IDLE;
        end else if (lat_q.fast && tach_ok) begin
          state_d = FSU_IDLE;
        end else if (tick) begin
          if (cnt_q == last_cnt) state_d = FSU_IDLE;
          else                   cnt_d   = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = FSU_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FSU_IDLE;
      cnt_q   <= '0;
      lat_q   <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lat_q   <= lat_d;
      start_q <= start_req;
    end
  end

  assign active  = (state_q == FSU_SPIN);
  assign cfg_lat = lat_q;

  // R6: an enabled start edge in idle enters spin-up
  a_r6_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FSU_IDLE && start_req && !start_q && cfg_ok) |=> (state_q == FSU_SPIN));

  // R3: a zero time code never leaves idle
  a_r3_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FSU_IDLE && cfg_i.time_code == 3'd0) |=> (state_q == FSU_IDLE));

  // R4: zero duty code without fast mode never leaves idle
  a_r4_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FSU_IDLE && !cfg_i.fast && cfg_i.duty_code == DC_OFF) |=> (state_q == FSU_IDLE));

  // R8: dropping the request aborts
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FSU_SPIN && !start_req) |=> (state_q == FSU_IDLE));

  // R7: tachometer flag ends fast spin-up
  a_r7_tach_end: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FSU_SPIN && lat_q.fast && tach_ok) |=> (state_q == FSU_IDLE));

  // R10: captured settings stay put through spin-up
  a_r10_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FSU_SPIN) |=> $stable(lat_q));

  // R2: the tick counter stays below the captured length
  a_r2_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FSU_SPIN) |-> (cnt_q < limit));

endmodule

// File: rtl/fsu_duty_sel.sv
module fsu_duty_sel
  import fsu_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  fsu_cfg_t          cfg_lat,
  input  logic [DUTY_W-1:0] norm_duty,
  output logic [DUTY_W-1:0] eff_duty
);

  localparam logic [DUTY_W-1:0] D_FULL = {DUTY_W{1'b1}};
  localparam logic [DUTY_W-1:0] D_HALF = DUTY_W'(1) << (DUTY_W - 1);
  localparam logic [DUTY_W-1:0] D_3Q   = D_HALF | (DUTY_W'(1) << (DUTY_W - 2));

  logic [DUTY_W-1:0] spin_duty;

  always_comb begin
    if (cfg_lat.fast) begin
      spin_duty = D_FULL;
    end else begin
      case (cfg_lat.duty_code)
        DC_HALF: spin_duty = D_HALF;
        DC_3Q:   spin_duty = D_3Q;
        DC_FULL: spin_duty = D_FULL;
        default: spin_duty = D_FULL;
      endcase
    end
  end

  always_comb begin
    eff_duty = active ? spin_duty : norm_duty;
  end

  // R5: fast spin-up always drives full duty
  a_r5_fast_full: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cfg_lat.fast) |-> (eff_duty == D_FULL));

  // R5: a half-duty spin-up never exceeds the half level
  a_r5_half: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cfg_lat.fast && cfg_lat.duty_code == DC_HALF) |-> (eff_duty == D_HALF));

endmodule

// File: rtl/fan_spinup_seq.sv
module fan_spinup_seq
  import fsu_pkg::*;
#(
  parameter int DUTY_W     = 8,
  parameter int BASE_TICKS = 50,
  parameter int REG_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic [DUTY_W-1:0] norm_duty,
  input  logic              start_req,
  input  logic              tach_ok,
  output logic [DUTY_W-1:0] eff_duty,
  output logic              spin_active
);

  logic     rst_int_n;
  fsu_cfg_t cfg_cur;
  fsu_cfg_t cfg_lat;
  logic     active;

  fsu_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_int_n)
  );

  fsu_cfg_reg #(.REG_W(REG_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg_cur)
  );

  fsu_seq #(.BASE_TICKS(BASE_TICKS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (tick),
    .start_req (start_req),
    .tach_ok   (tach_ok),
    .cfg_i     (cfg_cur),
    .active    (active),
    .cfg_lat   (cfg_lat)
  );

  fsu_duty_sel #(.DUTY_W(DUTY_W)) u_duty (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .active    (active),
    .cfg_lat   (cfg_lat),
    .norm_duty (norm_duty),
    .eff_duty  (eff_duty)
  );

  assign spin_active = active;

  // R9: outside spin-up the normal duty reaches the output unchanged
  a_r9_pass: assert property (@(posedge clk) disable iff (!rst_int_n)
    !spin_active |-> (eff_duty == norm_duty));

endmodule

// File: tb/sim_fan_spinup_seq.sv
module sim_fan_spinup_seq;

  localparam int CLK_P = 10;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic [7:0] norm_duty;
  logic       start_req;
  logic       tach_ok;
  logic [7:0] eff_duty;
  logic       spin_active;

  int n_chk  = 0;
  int n_fail = 0;
  bit chk_en = 0;
  bit done   = 0;

  fan_spinup_seq u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .norm_duty(norm_duty), .start_req(start_req),
    .tach_ok(tach_ok), .eff_duty(eff_duty), .spin_active(spin_active)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // reference values derived from the requirements
  function automatic int f_len(input logic [2:0] tc);
    return 50 << (int'(tc) - 1);
  endfunction

  function automatic int f_spin(input logic fast, input logic [1:0] dc);
    if (fast) return 255;
    case (dc)
      2'b01:   return 128;
      2'b10:   return 192;
      default: return 255;
    endcase
  endfunction

  function automatic bit f_enabled(input logic [5:0] c);
    return (c[2:0] != 3'd0) && (c[5] || c[4:3] != 2'b00);
  endfunction

  // cycle model
  logic [5:0] m_cfg;
  bit         m_active;
  int         m_cnt, m_len;
  logic       m_fast;
  logic [1:0] m_dc;
  logic       m_start_q;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 6'h3F; m_active = 0; m_cnt = 0; m_len = 0;
      m_fast = 0; m_dc = 0; m_start_q = 0;
    end else begin
      if (m_active) begin
        if (!start_req) m_active = 0;
        else if (m_fast && tach_ok) m_active = 0;
        else if (tick) begin
          if (m_cnt == m_len - 1) m_active = 0;
          else m_cnt = m_cnt + 1;
        end
      end else if (start_req && !m_start_q && f_enabled(m_cfg)) begin
        m_active = 1; m_cnt = 0; m_len = f_len(m_cfg[2:0]);
        m_fast = m_cfg[5]; m_dc = m_cfg[4:3];
      end
      if (cfg_we) m_cfg = cfg_wdata[5:0];
      m_start_q = start_req;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      #2;
      chk("R6 model spin_active", int'(spin_active), int'(m_active));
      if (m_active) chk("R5 model spin duty", int'(eff_duty), f_spin(m_fast, m_dc));
      else          chk("R9 model pass-through", int'(eff_duty), int'(norm_duty));
      chk("R1 model readback", int'(cfg_rdata), int'({2'b00, m_cfg}));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  task automatic sample();
    @(negedge clk); #2;
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic fire();
    @(negedge clk); start_req = 1'b1;
  endtask

  task automatic stop();
    @(negedge clk); start_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_len(output int n);
    n = 0;
    fire();
    for (int i = 0; i < 5000; i++) begin
      sample();
      if (!spin_active) break;
      n++;
    end
  endtask

  initial begin
    int n;
    bit duty_ok;
    void'($urandom(32'd20240611));
    rst_n = 0; tick = 0; cfg_we = 0; cfg_wdata = 0; norm_duty = 8'd37;
    start_req = 0; tach_ok = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk_en = 1;

    // R1 reset value
    sample();
    chk("R1 reset readback", int'(cfg_rdata), 8'h3F);
    chk("R6 reset idle", int'(spin_active), 0);

    // R1 upper bits read zero
    wr_cfg(8'hFF); sample();
    chk("R1 upper bits zero", int'(cfg_rdata), 8'h3F);
    wr_cfg(8'hC0); sample();
    chk("R1 write zero fields", int'(cfg_rdata), 8'h00);

    tick = 1'b1;

    // R3 time code zero bypasses even in fast mode
    wr_cfg(8'b00_1_11_000); fire(); sample(); sample();
    chk("R3 zero time no spin", int'(spin_active), 0);
    chk("R3 duty passes", int'(eff_duty), 37);
    stop();

    // R4 duty code zero without fast bypasses
    wr_cfg(8'b00_0_00_001); fire(); sample(); sample();
    chk("R4 zero duty no spin", int'(spin_active), 0);
    stop();

    // R4 fast overrides zero duty code, R5 at full duty
    wr_cfg(8'b00_1_00_001); fire(); sample();
    chk("R4 fast with zero duty spins", int'(spin_active), 1);
    chk("R5 fast full duty", int'(eff_duty), 255);
    stop();

    // R5 and R6 each duty code
    for (int dc = 1; dc < 4; dc++) begin
      wr_cfg({2'b00, 1'b0, 2'(dc), 3'b111});
      fire(); #2;
      chk("R6 not before edge", int'(spin_active), 0);
      sample();
      chk("R6 active after start edge", int'(spin_active), 1);
      chk("R5 coded duty", int'(eff_duty), f_spin(1'b0, 2'(dc)));
      stop();
    end

    // R5 fast ignores duty code
    wr_cfg(8'b00_1_01_111); fire(); sample();
    chk("R5 fast ignores duty code", int'(eff_duty), 255);
    stop();

    // R2 exact lengths
    wr_cfg(8'b00_0_11_001); run_len(n); chk("R2 length code 1", n, 50); stop();
    wr_cfg(8'b00_0_11_011); run_len(n); chk("R2 length code 3", n, 200); stop();
    wr_cfg(8'b00_0_11_111); run_len(n); chk("R2 length code 7", n, 3200);
    // R6 held request does not restart
    sample(); sample();
    chk("R6 no restart while held", int'(spin_active), 0);
    stop();

    // R7 fast mode ends on tach flag
    wr_cfg(8'b00_1_01_111); fire(); repeat (10) @(negedge clk);
    tach_ok = 1'b1; sample();
    chk("R7 tach ends fast spin", int'(spin_active), 0);
    tach_ok = 1'b0; stop();

    // R7 non-fast ignores tach flag
    wr_cfg(8'b00_0_01_111); fire(); repeat (5) @(negedge clk);
    tach_ok = 1'b1; sample(); sample();
    chk("R7 tach ignored non-fast", int'(spin_active), 1);
    chk("R7 duty kept non-fast", int'(eff_duty), 128);
    tach_ok = 1'b0; stop();

    // R8 abort on request drop
    wr_cfg(8'b00_0_10_111); fire(); repeat (5) @(negedge clk);
    norm_duty = 8'd90;
    @(negedge clk); start_req = 1'b0; #2;
    chk("R8 still on before edge", int'(spin_active), 1);
    sample();
    chk("R8 abort", int'(spin_active), 0);
    chk("R8 duty follows normal", int'(eff_duty), 90);
    repeat (2) @(negedge clk);

    // R9 combinational pass-through
    @(negedge clk); norm_duty = 8'd77; #1;
    chk("R9 same-cycle pass", int'(eff_duty), 77);

    // R10 write during spin-up
    wr_cfg(8'b00_0_01_001);
    n = 0; duty_ok = 1;
    fire();
    for (int i = 0; i < 500; i++) begin
      sample();
      if (!spin_active) break;
      n++;
      if (eff_duty != 8'd128) duty_ok = 0;
      if (n == 3) begin cfg_we = 1'b1; cfg_wdata = 8'b00_1_11_111; end
      else        cfg_we = 1'b0;
    end
    cfg_we = 1'b0;
    chk("R10 length unchanged", n, 50);
    chk("R10 duty unchanged", int'(duty_ok), 1);
    stop();

    // random phase
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      norm_duty = 8'($urandom);
      tick      = ($urandom % 3) == 0;
      tach_ok   = ($urandom % 30) == 0;
      if (($urandom % 40) == 0) start_req = ~start_req;
      cfg_we = ($urandom % 150) == 0;
      cfg_wdata = 8'($urandom);
    end
    @(negedge clk); cfg_we = 0; start_req = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule